// File: doc/BRIEF.md
# Frame Coordinate Mailbox

This block carries one object position per video frame from a pixel-clocked detection pipeline to a processor bus, where the two run on unrelated clocks. On the video side a detector presents a 16-bit X and a 16-bit Y value together with a one-cycle valid strobe. The block keeps the most recent pair that arrives during a frame. On the rising edge of vertical sync it hands that pair across the clock boundary. The handover uses a toggle request that is synchronised into the bus domain and a toggle acknowledge that is synchronised back. The launched word is held constant until the acknowledge returns.

On the bus side a small register slave with a one-bit word address holds the last delivered pair. It also has a status/control word with a sticky ready flag, a sticky overrun flag and an interrupt mask. Software can either poll the ready flag or use the level interrupt. A status read clears both sticky flags and the interrupt, so no bus read ever has to stall while waiting for data.

Two small state machines drive the block. The video machine has states V_IDLE (no transfer in flight) and V_BUSY (a word is launched and the acknowledge is outstanding). It moves V_IDLE→V_BUSY on a frame edge when a result is held, and V_BUSY→V_IDLE when the returned acknowledge equals the request. The bus flag machine has states F_EMPTY and F_FULL. It moves F_EMPTY→F_FULL when a delivery is detected, and F_FULL→F_EMPTY on a status read in a cycle with no delivery.

Top module: `coord_mailbox`

## Requirements
- R1: While either reset is low, and after both resets are released, the interrupt is 0, read data is 0, and status and coordinate registers read 0.
- R2: The coordinate register at word address 0 returns X in bits 31:16 and Y in bits 15:0 of the delivered pair.
- R3: A frame edge (vsync rising) with at least one valid result in that frame delivers the pair to the bus side; status bit 0 (ready) becomes 1 and, when unmasked, the interrupt rises.
- R4: Read data is registered: it shows the addressed register one bus clock after the read strobe, and it holds its value in cycles with no read, including write cycles.
- R5: Reading word address 1 returns status (bit 0 ready, bit 1 overrun, bit 2 interrupt mask) and then clears ready, overrun and the interrupt.
- R6: Writing word address 1 sets the interrupt mask from write data bit 0; while the mask is 1 the interrupt stays 0, but ready still sets.
- R7: Writes to word address 0 have no effect on the coordinate register.
- R8: A frame result whose edge comes while a transfer is still in flight is dropped; the earlier pair is the one delivered and status bit 1 (overrun) becomes 1.
- R9: A frame edge with no valid result in that frame delivers nothing and leaves ready at 0.
- R10: When several valid results arrive within one frame, the last one before the edge is delivered.
- R11: Asserting the bus reset alone clears ready, overrun, mask, the coordinate register and the interrupt.
- R12: Reading word address 0 does not clear the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vid_clk | input | 1 | Pixel clock of the detection path |
| vid_rst_n | input | 1 | Active-low asynchronous reset of the video side |
| vid_x | input | 16 | Detected X coordinate |
| vid_y | input | 16 | Detected Y coordinate |
| vid_valid | input | 1 | One-cycle strobe marking vid_x/vid_y as a result |
| vid_vsync | input | 1 | Vertical sync; rising edge ends a frame |
| bus_clk | input | 1 | Processor bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset of the bus side |
| bus_addr | input | 1 | Word address: 0 coordinate, 1 status/control |
| bus_write | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_read | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: ready and not masked |

## Verification
The bench targets a second frame edge that comes while the acknowledge is still outstanding. A design without the busy guard would overwrite the launched word mid-crossing or lose the overrun mark, and the bench would read back the second pair or an overrun bit of 0. It also covers a frame with no valid strobe, which a design tracking only vsync would publish as a stale ready. It covers two strobes in one frame, where the first one kept would show up as the wrong pair. Other cases are a data-address read, which must not clear ready, and a mask write, after which a leaking interrupt shows up at once against the bench's per-cycle model. A bus-only reset must not trigger a spurious delivery afterwards.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
    typedef enum logic {V_IDLE, V_BUSY} vid_state_t;
    typedef enum logic {F_EMPTY, F_FULL} flag_state_t;

    localparam logic ADDR_COORD = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    localparam int ST_READY_BIT  = 0;
    localparam int ST_OVR_BIT    = 1;
    localparam int ST_MASK_BIT   = 2;
    localparam int CTRL_MASK_BIT = 0;
endpackage

// File: rtl/cmb_rst_sync.sv
module cmb_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], 1'b1};
        end
    end

    assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/cmb_bit_sync.sv
module cmb_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cmb_vid_capture.sv
module cmb_vid_capture
    import cmb_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int WORD_W  = 2 * COORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COORD_W-1:0] x_in,
    input  logic [COORD_W-1:0] y_in,
    input  logic              valid,
    input  logic              vsync,
    input  logic              ack_tog,
    output logic              req_tog,
    output logic              ovr_tog,
    output logic [WORD_W-1:0] launch_word
);
    vid_state_t        state_q, state_d;
    logic              vsync_q, have_q, req_q, ovr_q;
    logic [WORD_W-1:0] stage_q, launch_q;
    logic              frame_edge, do_launch, do_drop;

    // next state and transfer decisions
    always_comb begin
        frame_edge = vsync & ~vsync_q;
        do_launch  = 1'b0;
        do_drop    = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            V_IDLE: begin
                if (frame_edge && have_q) begin
                    do_launch = 1'b1;
                    state_d   = V_BUSY;
                end
            end
            V_BUSY: begin
                if (frame_edge && have_q) begin
                    do_drop = 1'b1;
                end
                if (ack_tog == req_q) begin
                    state_d = V_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= V_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsync_q  <= 1'b0;
            have_q   <= 1'b0;
            req_q    <= 1'b0;
            ovr_q    <= 1'b0;
            stage_q  <= '0;
            launch_q <= '0;
        end else begin
            vsync_q <= vsync;
            if (valid) begin
                stage_q <= {x_in, y_in};
                have_q  <= 1'b1;
            end else if (frame_edge) begin
                have_q <= 1'b0;
            end
            if (do_launch) begin
                launch_q <= stage_q;
                req_q    <= ~req_q;
            end
            if (do_drop) begin
                ovr_q <= ~ovr_q;
            end
        end
    end

    assign req_tog     = req_q;
    assign ovr_tog     = ovr_q;
    assign launch_word = launch_q;

    // R8: the launched word may not move while its transfer is outstanding
    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == V_BUSY) |=> $stable(launch_word));

    // R8: a result at a busy frame edge raises no new request
    a_r8_no_request_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == V_BUSY && frame_edge) |=> $stable(req_tog));

    // R9: without a held result a frame edge launches nothing
    a_r9_no_result_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && !have_q) |=> $stable(req_tog));
endmodule

// File: rtl/cmb_bus_regs.sv
module cmb_bus_regs
    import cmb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    input  logic              read,
    input  logic              req_sync,
    input  logic              ovr_sync,
    input  logic [DATA_W-1:0] launch_word,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              ack_tog
);
    flag_state_t       state_q, state_d;
    logic              req_prev_q, ovr_prev_q;
    logic              overrun_q, overrun_d, mask_q, mask_d, irq_q;
    logic [DATA_W-1:0] coord_q, rdata_q, status_word;
    logic              arrival, ovr_event, status_rd;
    logic              wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:1];

    // Toggle trackers follow the synchronised levels without reset so
    // that a bus-only reset never invents a delivery.
    always_ff @(posedge clk) begin
        req_prev_q <= req_sync;
        ovr_prev_q <= ovr_sync;
    end

    always_comb begin
        arrival   = req_sync ^ req_prev_q;
        ovr_event = ovr_sync ^ ovr_prev_q;
        status_rd = read && (addr == ADDR_CTRL);
        state_d   = state_q;
        unique case (state_q)
            F_EMPTY: if (arrival) state_d = F_FULL;
            F_FULL:  if (status_rd && !arrival) state_d = F_EMPTY;
        endcase
        mask_d    = (write && addr == ADDR_CTRL) ? wdata[CTRL_MASK_BIT] : mask_q;
        overrun_d = ovr_event ? 1'b1 : (status_rd ? 1'b0 : overrun_q);
        status_word               = '0;
        status_word[ST_READY_BIT] = (state_q == F_FULL);
        status_word[ST_OVR_BIT]   = overrun_q;
        status_word[ST_MASK_BIT]  = mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= F_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun_q <= 1'b0;
            mask_q    <= 1'b0;
            irq_q     <= 1'b0;
            coord_q   <= '0;
            rdata_q   <= '0;
        end else begin
            overrun_q <= overrun_d;
            mask_q    <= mask_d;
            irq_q     <= (state_d == F_FULL) && !mask_d;
            if (arrival) begin
                coord_q <= launch_word;
            end
            if (read) begin
                rdata_q <= (addr == ADDR_CTRL) ? status_word : coord_q;
            end
        end
    end

    assign rdata   = rdata_q;
    assign irq     = irq_q;
    assign ack_tog = req_prev_q;

    // R3: a detected delivery sets the ready flag
    a_r3_arrival_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        arrival |=> (state_q == F_FULL));

    // R5: a status read with no competing delivery empties the flag and drops irq
    a_r5_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !arrival) |=> (state_q == F_EMPTY && !irq));

    // R5: overrun clears on a status read with no new drop event
    a_r5_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !ovr_event) |=> !overrun_q);

    // R4: read data holds when no read is issued
    a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !read |=> $stable(rdata));

    // R6: a set mask keeps the interrupt low
    a_r6_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq);

    // R7: writes to the coordinate address leave it unchanged
    a_r7_coord_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (write && addr == ADDR_COORD && !arrival) |=> $stable(coord_q));

    // R12: a coordinate read keeps a set ready flag
    a_r12_coord_read_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (read && addr == ADDR_COORD && state_q == F_FULL) |=> (state_q == F_FULL));
endmodule

// File: rtl/coord_mailbox.sv
module coord_mailbox #(
    parameter int COORD_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   vid_clk,
    input  logic                   vid_rst_n,
    input  logic [COORD_W-1:0]     vid_x,
    input  logic [COORD_W-1:0]     vid_y,
    input  logic                   vid_valid,
    input  logic                   vid_vsync,
    input  logic                   bus_clk,
    input  logic                   bus_rst_n,
    input  logic                   bus_addr,
    input  logic                   bus_write,
    input  logic [2*COORD_W-1:0]   bus_wdata,
    input  logic                   bus_read,
    output logic [2*COORD_W-1:0]   bus_rdata,
    output logic                   irq
);
    localparam int WORD_W = 2 * COORD_W;

    logic              vid_srst_n, bus_srst_n;
    logic              req_tog, ovr_tog, ack_tog;
    logic              req_at_bus, ovr_at_bus, ack_at_vid;
    logic [WORD_W-1:0] launch_word;

    cmb_rst_sync #(.STAGES(SYNC_STAGES)) u_vid_rst (
        .clk(vid_clk), .arst_n(vid_rst_n), .srst_n(vid_srst_n));

    cmb_rst_sync #(.STAGES(SYNC_STAGES)) u_bus_rst (
        .clk(bus_clk), .arst_n(bus_rst_n), .srst_n(bus_srst_n));

    cmb_vid_capture #(.COORD_W(COORD_W), .WORD_W(WORD_W)) u_capture (
        .clk(vid_clk), .rst_n(vid_srst_n),
        .x_in(vid_x), .y_in(vid_y), .valid(vid_valid), .vsync(vid_vsync),
        .ack_tog(ack_at_vid), .req_tog(req_tog), .ovr_tog(ovr_tog),
        .launch_word(launch_word));

    cmb_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(bus_clk), .d(req_tog), .q(req_at_bus));

    cmb_bit_sync #(.STAGES(SYNC_STAGES)) u_ovr_sync (
        .clk(bus_clk), .d(ovr_tog), .q(ovr_at_bus));

    cmb_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(vid_clk), .d(ack_tog), .q(ack_at_vid));

    cmb_bus_regs #(.DATA_W(WORD_W)) u_regs (
        .clk(bus_clk), .rst_n(bus_srst_n),
        .addr(bus_addr), .write(bus_write), .wdata(bus_wdata), .read(bus_read),
        .req_sync(req_at_bus), .ovr_sync(ovr_at_bus), .launch_word(launch_word),
        .rdata(bus_rdata), .irq(irq), .ack_tog(ack_tog));
endmodule

// File: tb/sim_coord_mailbox.sv
`timescale 1ns/1ps
module sim_coord_mailbox;
    logic        vid_clk = 0, bus_clk = 0;
    logic        vid_rst_n = 0, bus_rst_n = 0;
    logic [15:0] vid_x = 0, vid_y = 0;
    logic        vid_valid = 0, vid_vsync = 0;
    logic        bus_addr = 0, bus_write = 0, bus_read = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 0;
    bit in_flight = 0;
    bit exp_ready = 0, exp_mask = 0;
    logic [31:0] rd;

    always #2.5 bus_clk = ~bus_clk;   // 200 MHz
    always #4   vid_clk = ~vid_clk;

    coord_mailbox u0 (
        .vid_clk(vid_clk), .vid_rst_n(vid_rst_n), .vid_x(vid_x), .vid_y(vid_y),
        .vid_valid(vid_valid), .vid_vsync(vid_vsync),
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_read(bus_read),
        .bus_rdata(bus_rdata), .irq(irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle model comparison of the interrupt (R3, R5, R6)
    always @(negedge bus_clk) begin
        #1;
        if (!done && !in_flight)
            chk("R3/R6 irq model", {31'b0, irq}, {31'b0, exp_ready && !exp_mask});
    end

    task automatic bus_rd(input logic a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a; bus_read = 1;
        @(negedge bus_clk);
        bus_read = 0;
        d = bus_rdata;
        if (a) begin exp_ready = 0; end
    endtask

    task automatic bus_wr(input logic a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a; bus_write = 1; bus_wdata = d;
        @(negedge bus_clk);
        bus_write = 0;
        if (a) exp_mask = d[0];
    endtask

    task automatic settle(input bit delivers);
        repeat (20) @(negedge bus_clk);
        if (delivers) exp_ready = 1;
        in_flight = 0;
    endtask

    task automatic frame(input int nvalid, input logic [15:0] x1, y1, x2, y2);
        in_flight = 1;
        if (nvalid >= 1) begin
            @(negedge vid_clk); vid_valid = 1; vid_x = x1; vid_y = y1;
        end
        if (nvalid >= 2) begin
            @(negedge vid_clk); vid_x = x2; vid_y = y2;
        end
        @(negedge vid_clk); vid_valid = 0; vid_vsync = 1;
        @(negedge vid_clk); vid_vsync = 0;
        repeat (3) @(negedge vid_clk);
        settle(nvalid > 0);
    endtask

    initial begin
        repeat (10) @(negedge bus_clk);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        chk("R1 rdata in reset", bus_rdata, 32'h0);
        vid_rst_n = 1; bus_rst_n = 1;
        repeat (6) @(negedge bus_clk);
        bus_rd(1, rd); chk("R1 status after reset", rd, 32'h0);
        bus_rd(0, rd); chk("R1 coord after reset", rd, 32'h0);

        frame(1, 16'h1234, 16'h5678, 0, 0);
        chk("R3 irq after delivery", {31'b0, irq}, 32'h1);
        bus_rd(0, rd); chk("R2 coord packing", rd, 32'h1234_5678);
        chk("R12 irq after coord read", {31'b0, irq}, 32'h1);
        exp_ready = 1;
        bus_rd(1, rd); chk("R12 ready kept by coord read", rd, 32'h1);
        chk("R5 irq cleared by status read", {31'b0, irq}, 32'h0);
        bus_rd(1, rd); chk("R5 status cleared", rd, 32'h0);

        bus_wr(0, 32'hDEAD_BEEF);
        chk("R4 rdata holds over write", bus_rdata, 32'h0);
        bus_rd(0, rd); chk("R7 coord write ignored", rd, 32'h1234_5678);
        repeat (3) @(negedge bus_clk);
        chk("R4 rdata holds idle", bus_rdata, 32'h1234_5678);

        frame(2, 16'hAAAA, 16'h0001, 16'hBBBB, 16'h0002);
        bus_rd(0, rd); chk("R10 last valid wins", rd, 32'hBBBB_0002);
        bus_rd(1, rd); chk("R10 status", rd, 32'h1);

        frame(0, 0, 0, 0, 0);
        bus_rd(1, rd); chk("R9 no result no ready", rd, 32'h0);
        bus_rd(0, rd); chk("R9 coord unchanged", rd, 32'hBBBB_0002);

        bus_wr(1, 32'h1);
        bus_rd(1, rd); chk("R6 mask visible", rd, 32'h4);
        frame(1, 16'h0F0F, 16'hF0F0, 0, 0);
        chk("R6 irq masked", {31'b0, irq}, 32'h0);
        bus_rd(1, rd); chk("R6 ready sets under mask", rd, 32'h5);
        bus_wr(1, 32'h0);

        // R8: second frame edge while the first transfer is still in flight
        in_flight = 1;
        @(negedge vid_clk); vid_valid = 1; vid_x = 16'h1111; vid_y = 16'h2222;
        @(negedge vid_clk); vid_x = 16'h3333; vid_y = 16'h4444; vid_vsync = 1;
        @(negedge vid_clk); vid_valid = 0; vid_vsync = 0;
        @(negedge vid_clk); vid_vsync = 1;
        @(negedge vid_clk); vid_vsync = 0;
        settle(1);
        bus_rd(0, rd); chk("R8 first pair delivered", rd, 32'h1111_2222);
        bus_rd(1, rd); chk("R8 overrun flagged", rd, 32'h3);
        bus_rd(1, rd); chk("R5 overrun cleared", rd, 32'h0);

        @(negedge bus_clk); bus_addr = 1; bus_read = 1;
        #1 chk("R4 rdata before edge", bus_rdata, 32'h0);
        @(negedge bus_clk); bus_read = 0; exp_ready = 0;
        chk("R4 rdata one cycle later", bus_rdata, 32'h0);

        bus_wr(1, 32'h1);
        frame(1, 16'h7777, 16'h8888, 0, 0);
        @(negedge bus_clk);
        bus_rst_n = 0; exp_ready = 0; exp_mask = 0;
        repeat (3) @(negedge bus_clk);
        bus_rst_n = 1;
        repeat (6) @(negedge bus_clk);
        chk("R11 irq after bus reset", {31'b0, irq}, 32'h0);
        bus_rd(1, rd); chk("R11 status after bus reset", rd, 32'h0);
        bus_rd(0, rd); chk("R11 coord after bus reset", rd, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule